// File: doc/BRIEF.md
# Two-Speed Start-Up Clock Controller

This block decides which oscillator clocks the core after a power-on reset or a wake from sleep. When a crystal-based primary oscillator is configured and the fast start-up option is enabled, the core runs at once from the internal oscillator while an oscillator start-up counter waits for the crystal to settle. In the PLL crystal modes a further lock interval follows. The block then moves the system clock to the primary source by itself and raises a registered status bit.

Software keeps full control during the fallback phase. It may select the internal oscillator through the clock-select bits, or issue a sleep request before the wait has finished. A sleep request stops and clears the start-up counters, so the next wake restarts the whole sequence. Every handover between sources goes through a glitch-free clock multiplexer: the old source is released on its own falling edge before the new source is enabled.

The controller logic runs on the internal clock. Sleep requests and wake events are single-cycle pulses that are synchronous to that clock. No data stream passes through the block, so every pin is a plain control or status signal.

Top module: `tsu_clk_ctrl`

## Requirements
- R1: While `por_n` is low, and after its release until `pwrt_done` is high, `run_mode` is 0, `pri_active` is 0 and `sys_clk` stays low.
- R2: With `cfg_fast_en` high and a crystal mode (codes 0 to 3), leaving reset or sleep gives `run_mode` 1. In that state `sys_clk` follows `int_clk` at its own rate with no division, and `pri_active` is 0.
- R3: `run_mode` 1 lasts at least `OST_CYCLES` periods of `pri_clk`, and ends within a few internal cycles after that count completes.
- R4: In the PLL crystal modes (codes 2 and 3), the end of the start-up count gives `run_mode` 2 for exactly `LOCK_CYCLES` internal cycles. After that the state is `run_mode` 3 with `sys_clk` taken from `pll_clk`.
- R5: In the non-PLL crystal modes (codes 0 and 1), `run_mode` goes from 1 straight to 3, and `sys_clk` is taken from `pri_clk`.
- R6: In a non-crystal mode (codes 4 to 7), leaving reset or sleep goes directly to `run_mode` 3 with no start-up wait, whatever `cfg_fast_en` is. `sys_clk` is then taken from `pri_clk`.
- R7: With `cfg_fast_en` low and a crystal mode, the start-up wait still takes place in `run_mode` 1, but `sys_clk` is held low until `run_mode` 3.
- R8: A `sleep_req` pulse in `run_mode` 1, 2 or 3 gives `run_mode` 4 (sleep) on the next cycle. In sleep, `sys_clk` stops and `pri_active` is 0. A `wake` pulse has no effect outside sleep.
- R9: A sleep request during start-up clears the start-up and lock counters. The next wake restarts a full `OST_CYCLES` wait. A wake that arrives before the clear has completed is held and acted on afterwards.
- R10: When `clk_sel` is not 2'b00, `run_mode` 3 clocks `sys_clk` from `int_clk` and `pri_active` is 0. Returning `clk_sel` to 2'b00 moves `sys_clk` back to the primary source.
- R11: `pri_active` is a register. It is 1 exactly when `run_mode` is 3 and `clk_sel` was 2'b00 at the previous clock edge.
- R12: At most one source is enabled into `sys_clk` at any time, and no high pulse of `sys_clk` is shorter than the shortest half period of the sources.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| int_clk | input | 1 | Internal oscillator clock. It also clocks the controller. |
| pri_clk | input | 1 | Primary oscillator clock (crystal or external source) |
| pll_clk | input | 1 | Output of the PLL fed by the primary oscillator |
| por_n | input | 1 | Asynchronous active-low power-on reset |
| pwrt_done | input | 1 | Power-up timer has expired |
| wake | input | 1 | Wake-event pulse, synchronous to `int_clk` |
| sleep_req | input | 1 | Sleep-request pulse, synchronous to `int_clk` |
| cfg_fast_en | input | 1 | Configuration bit that enables the fast start-up path |
| pri_mode | input | 3 | Primary mode: 0/1 low/high-speed crystal, 2/3 the same with PLL, 4-7 non-crystal |
| clk_sel | input | 2 | Software clock select: 2'b00 primary, any other value internal |
| sys_clk | output | 1 | Selected, glitch-free system clock |
| pri_active | output | 1 | Registered flag: the primary source is clocking the core |
| run_mode | output | 3 | State: 0 reset wait, 1 internal run during start-up wait, 2 internal run during PLL lock, 3 primary run, 4 sleep |

## Verification
The bench keeps `OST_CYCLES` at its real value of 1024 but lowers `LOCK_CYCLES` to 300 in place of the default of about 2 ms, so the PLL path and its exact lock length can be reached in a short run. The three clocks use distinct periods of 10, 14 and 4 ns. Counting `sys_clk` edges over a fixed window therefore identifies the active source, and measuring high-pulse widths can expose a runt at any handover. With these values the bench can also place a sleep request part way through the start-up count and observe that the following wait starts again at full length.

// File: rtl/tsu_pkg.sv
`timescale 1ns/1ps
package tsu_pkg;

  typedef enum logic [2:0] {
    ST_RESET_WAIT = 3'd0,
    ST_INT_OST    = 3'd1,
    ST_INT_PLL    = 3'd2,
    ST_PRI_RUN    = 3'd3,
    ST_SLEEP      = 3'd4
  } tsu_state_e;

  localparam int NUM_SRC = 3;
  localparam int SEL_W   = $clog2(NUM_SRC + 1);

  // mux source indices; the value NUM_SRC means no source
  localparam logic [SEL_W-1:0] SEL_INT  = SEL_W'(0);
  localparam logic [SEL_W-1:0] SEL_PRI  = SEL_W'(1);
  localparam logic [SEL_W-1:0] SEL_PLL  = SEL_W'(2);
  localparam logic [SEL_W-1:0] SEL_NONE = SEL_W'(NUM_SRC);

  function automatic logic is_crystal(input logic [2:0] mode);
    return !mode[2];
  endfunction

  function automatic logic is_pll(input logic [2:0] mode);
    return (mode[2:1] == 2'b01);
  endfunction

endpackage

// File: rtl/tsu_ost_timer.sv
`timescale 1ns/1ps
// Oscillator start-up counter. It counts in the primary clock domain and
// reports done and idle (cleared) back in the internal clock domain.
module tsu_ost_timer #(
  parameter int OST_CYCLES = 1024
) (
  input  logic int_clk,
  input  logic pri_clk,
  input  logic rst_n,
  input  logic run,
  output logic done,
  output logic idle
);
  localparam int CW = $clog2(OST_CYCLES + 1);

  logic [1:0]    run_sync;
  logic [CW-1:0] cnt;
  logic          done_p;
  logic          idle_p;
  logic [1:0]    done_sync;
  logic [1:0]    idle_sync;

  always_ff @(posedge pri_clk or negedge rst_n) begin
    if (!rst_n) run_sync <= 2'b00;
    else        run_sync <= {run_sync[0], run};
  end

  // idle_p goes high together with the cleared count
  always_ff @(posedge pri_clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      done_p <= 1'b0;
      idle_p <= 1'b1;
    end else if (!run_sync[1]) begin
      cnt    <= '0;
      done_p <= 1'b0;
      idle_p <= 1'b1;
    end else begin
      idle_p <= 1'b0;
      if (cnt != CW'(OST_CYCLES)) cnt <= cnt + 1'b1;
      done_p <= done_p | (cnt == CW'(OST_CYCLES - 1));
    end
  end

  always_ff @(posedge int_clk or negedge rst_n) begin
    if (!rst_n) begin
      done_sync <= 2'b00;
      idle_sync <= 2'b00;
    end else begin
      done_sync <= {done_sync[0], done_p};
      idle_sync <= {idle_sync[0], idle_p};
    end
  end

  assign done = done_sync[1];
  assign idle = idle_sync[1];
endmodule

// File: rtl/tsu_lock_timer.sv
`timescale 1ns/1ps
// PLL lock interval, counted in internal-clock cycles.
module tsu_lock_timer #(
  parameter int LOCK_CYCLES = 16000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic done
);
  localparam int LW = (LOCK_CYCLES > 1) ? $clog2(LOCK_CYCLES) : 1;

  logic [LW-1:0] cnt;

  assign done = run && (cnt == LW'(LOCK_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (!run)  cnt <= '0;
    else if (!done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/tsu_seq_fsm.sv
`timescale 1ns/1ps
// Start-up sequencer: state, source choice and registered status.
module tsu_seq_fsm
  import tsu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwrt_done,
  input  logic             wake,
  input  logic             sleep_req,
  input  logic             cfg_fast_en,
  input  logic [2:0]       pri_mode,
  input  logic [1:0]       clk_sel,
  input  logic             ost_done,
  input  logic             ost_idle,
  input  logic             lock_done,
  output tsu_state_e       state_q,
  output logic             ost_run,
  output logic             lock_run,
  output logic [SEL_W-1:0] src_sel,
  output logic             pri_active
);
  tsu_state_e       nxt;
  tsu_state_e       start_st;
  logic [SEL_W-1:0] sel_nxt;
  logic             wake_pend;

  always_comb begin
    start_st = is_crystal(pri_mode) ? ST_INT_OST : ST_PRI_RUN;
    nxt      = state_q;
    unique case (state_q)
      ST_RESET_WAIT: if (pwrt_done && ost_idle) nxt = start_st;
      ST_INT_OST: begin
        if (sleep_req)     nxt = ST_SLEEP;
        else if (ost_done) nxt = is_pll(pri_mode) ? ST_INT_PLL : ST_PRI_RUN;
      end
      ST_INT_PLL: begin
        if (sleep_req)      nxt = ST_SLEEP;
        else if (lock_done) nxt = ST_PRI_RUN;
      end
      ST_PRI_RUN: if (sleep_req) nxt = ST_SLEEP;
      ST_SLEEP:   if ((wake || wake_pend) && ost_idle) nxt = start_st;
      default:    nxt = ST_RESET_WAIT;
    endcase
  end

  always_comb begin
    unique case (nxt)
      ST_INT_OST, ST_INT_PLL: sel_nxt = cfg_fast_en ? SEL_INT : SEL_NONE;
      ST_PRI_RUN: begin
        if (clk_sel != 2'b00)      sel_nxt = SEL_INT;
        else if (is_pll(pri_mode)) sel_nxt = SEL_PLL;
        else                       sel_nxt = SEL_PRI;
      end
      default: sel_nxt = SEL_NONE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_RESET_WAIT;
      src_sel    <= SEL_NONE;
      pri_active <= 1'b0;
      wake_pend  <= 1'b0;
    end else begin
      state_q    <= nxt;
      src_sel    <= sel_nxt;
      pri_active <= (nxt == ST_PRI_RUN) && (clk_sel == 2'b00);
      wake_pend  <= (state_q == ST_SLEEP) && (wake || wake_pend);
    end
  end

  assign ost_run  = (state_q == ST_INT_OST);
  assign lock_run = (state_q == ST_INT_PLL);
endmodule

// File: rtl/tsu_clk_mux.sv
`timescale 1ns/1ps
// Glitch-free N-way clock mux. Each source has its own enable, which is
// set in two stages (rising, then falling edge of that source) and only
// while every other enable is low.
module tsu_clk_mux #(
  parameter int N  = 3,
  parameter int SW = $clog2(N + 1)
) (
  input  logic [N-1:0]  clk_src,
  input  logic          rst_n,
  input  logic [SW-1:0] sel,
  output logic          clk_out,
  output logic [N-1:0]  src_en
);
  for (genvar i = 0; i < N; i++) begin : g_src
    logic stage1;
    logic stage2;
    logic others_on;

    assign others_on = |(src_en & ~(N'(1) << i));

    always_ff @(posedge clk_src[i] or negedge rst_n) begin
      if (!rst_n) stage1 <= 1'b0;
      else        stage1 <= (sel == SW'(i)) && !others_on;
    end

    always_ff @(negedge clk_src[i] or negedge rst_n) begin
      if (!rst_n) stage2 <= 1'b0;
      else        stage2 <= stage1;
    end

    assign src_en[i] = stage2;
  end

  assign clk_out = |(clk_src & src_en);
endmodule

// File: rtl/tsu_clk_ctrl.sv
`timescale 1ns/1ps
module tsu_clk_ctrl
  import tsu_pkg::*;
#(
  parameter int OST_CYCLES  = 1024,
  parameter int LOCK_CYCLES = 16000
) (
  input  logic       int_clk,
  input  logic       pri_clk,
  input  logic       pll_clk,
  input  logic       por_n,
  input  logic       pwrt_done,
  input  logic       wake,
  input  logic       sleep_req,
  input  logic       cfg_fast_en,
  input  logic [2:0] pri_mode,
  input  logic [1:0] clk_sel,
  output logic       sys_clk,
  output logic       pri_active,
  output logic [2:0] run_mode
);
  tsu_state_e         state;
  logic               ost_run;
  logic               lock_run;
  logic               ost_done;
  logic               ost_idle;
  logic               lock_done;
  logic [SEL_W-1:0]   src_sel;
  logic [NUM_SRC-1:0] src_en;

  tsu_ost_timer #(.OST_CYCLES(OST_CYCLES)) u_ost (
    .int_clk (int_clk),
    .pri_clk (pri_clk),
    .rst_n   (por_n),
    .run     (ost_run),
    .done    (ost_done),
    .idle    (ost_idle)
  );

  tsu_lock_timer #(.LOCK_CYCLES(LOCK_CYCLES)) u_lock (
    .clk   (int_clk),
    .rst_n (por_n),
    .run   (lock_run),
    .done  (lock_done)
  );

  tsu_seq_fsm u_fsm (
    .clk         (int_clk),
    .rst_n       (por_n),
    .pwrt_done   (pwrt_done),
    .wake        (wake),
    .sleep_req   (sleep_req),
    .cfg_fast_en (cfg_fast_en),
    .pri_mode    (pri_mode),
    .clk_sel     (clk_sel),
    .ost_done    (ost_done),
    .ost_idle    (ost_idle),
    .lock_done   (lock_done),
    .state_q     (state),
    .ost_run     (ost_run),
    .lock_run    (lock_run),
    .src_sel     (src_sel),
    .pri_active  (pri_active)
  );

  tsu_clk_mux #(.N(NUM_SRC), .SW(SEL_W)) u_mux (
    .clk_src ({pll_clk, pri_clk, int_clk}),
    .rst_n   (por_n),
    .sel     (src_sel),
    .clk_out (sys_clk),
    .src_en  (src_en)
  );

  assign run_mode = state;
endmodule

// File: rtl/tsu_clk_ctrl_chk.sv
`timescale 1ns/1ps
module tsu_clk_ctrl_chk (
  input logic       int_clk,
  input logic       por_n,
  input logic [2:0] run_mode,
  input logic [2:0] pri_mode,
  input logic [1:0] clk_sel,
  input logic       pri_active,
  input logic       sleep_req,
  input logic [2:0] src_en
);
  assert_reset_idle_R1: assert property (@(posedge int_clk) disable iff (!por_n)
    (run_mode == 3'd0) |-> !pri_active);

  assert_pll_lock_mode_R4: assert property (@(posedge int_clk) disable iff (!por_n)
    (run_mode == 3'd2) |-> (pri_mode[2:1] == 2'b01));

  assert_direct_handover_R5: assert property (@(posedge int_clk) disable iff (!por_n)
    ($past(run_mode) == 3'd1 && run_mode == 3'd3) |-> !$past(pri_mode[1]));

  assert_start_path_R6: assert property (@(posedge int_clk) disable iff (!por_n)
    (($past(run_mode) == 3'd0 || $past(run_mode) == 3'd4) && run_mode != $past(run_mode))
      |-> ((run_mode == 3'd3) == $past(pri_mode[2])));

  assert_sleep_entry_R8: assert property (@(posedge int_clk) disable iff (!por_n)
    (sleep_req && (run_mode == 3'd1 || run_mode == 3'd2 || run_mode == 3'd3))
      |=> (run_mode == 3'd4));

  assert_status_flag_R11: assert property (@(posedge int_clk) disable iff (!por_n)
    pri_active == (run_mode == 3'd3 && $past(clk_sel) == 2'b00));

  assert_single_source_R12: assert property (@(posedge int_clk) disable iff (!por_n)
    $onehot0(src_en));
endmodule

bind tsu_clk_ctrl tsu_clk_ctrl_chk u_chk (
  .int_clk    (int_clk),
  .por_n      (por_n),
  .run_mode   (run_mode),
  .pri_mode   (pri_mode),
  .clk_sel    (clk_sel),
  .pri_active (pri_active),
  .sleep_req  (sleep_req),
  .src_en     (src_en)
);

// File: tb/tsu_clk_ctrl_tb.sv
`timescale 1ns/1ps
module tsu_clk_ctrl_tb;
  localparam int OST  = 1024;
  localparam int LOCK = 300;
  localparam int OST_MIN = (OST * 14) / 10;
  localparam int OST_MAX = OST_MIN + 12;

  logic int_clk = 1'b0, pri_clk = 1'b0, pll_clk = 1'b0;
  logic por_n = 1'b0, pwrt_done = 1'b0, wake = 1'b0, sleep_req = 1'b0;
  logic cfg_fast_en = 1'b1;
  logic [2:0] pri_mode = 3'd1;
  logic [1:0] clk_sel = 2'b00;
  logic sys_clk, pri_active;
  logic [2:0] run_mode;

  int checks = 0, fails = 0;
  int cyc = 0, entry_cyc = 0;
  int last_dur [8];
  int sys_edges = 0;
  logic [2:0] prev_mode = 3'd0;
  logic [2:0] exp_q [$];
  string      tag_q [$];
  realtime t_rise = 0.0, min_high = 1.0e9;
  bit have_rise = 1'b0;

  always #5 int_clk = ~int_clk;
  initial begin #3;   forever #7 pri_clk = ~pri_clk; end
  initial begin #0.5; forever #2 pll_clk = ~pll_clk; end

  tsu_clk_ctrl #(.OST_CYCLES(OST), .LOCK_CYCLES(LOCK)) u_dut (
    .int_clk(int_clk), .pri_clk(pri_clk), .pll_clk(pll_clk), .por_n(por_n),
    .pwrt_done(pwrt_done), .wake(wake), .sleep_req(sleep_req),
    .cfg_fast_en(cfg_fast_en), .pri_mode(pri_mode), .clk_sel(clk_sel),
    .sys_clk(sys_clk), .pri_active(pri_active), .run_mode(run_mode)
  );

  always @(posedge sys_clk) begin
    sys_edges++;
    t_rise = $realtime;
    have_rise = 1'b1;
  end
  always @(negedge sys_clk) begin
    if (have_rise && ($realtime - t_rise) < min_high) min_high = $realtime - t_rise;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic chk_rng(input string tag, input int act, input int lo, input int hi);
    chk(act >= lo && act <= hi, tag, act, lo);
  endtask

  // monitor: scoreboard of run_mode transitions
  always @(negedge int_clk) begin
    cyc++;
    if (por_n && run_mode !== prev_mode) begin
      last_dur[prev_mode] = cyc - entry_cyc;
      entry_cyc = cyc;
      if (exp_q.size() == 0) begin
        chk(1'b0, "R8 unexpected run_mode change", int'(run_mode), -1);
      end else begin
        automatic logic [2:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(e === run_mode, t, int'(run_mode), int'(e));
      end
      prev_mode = run_mode;
    end
  end

  task automatic push(input logic [2:0] m, input string tag);
    exp_q.push_back(m);
    tag_q.push_back(tag);
  endtask

  task automatic tick(input int n);
    repeat (n) begin
      @(negedge int_clk);
      #1;
    end
  endtask

  task automatic wait_mode(input logic [2:0] m, input int max, input string tag);
    int i;
    for (i = 0; i < max; i++) begin
      if (run_mode == m) break;
      tick(1);
    end
    chk(run_mode == m, tag, int'(run_mode), int'(m));
  endtask

  task automatic rate(input int n, output int cnt);
    int e0;
    e0 = sys_edges;
    tick(n);
    cnt = sys_edges - e0;
  endtask

  task automatic pulse_sleep();
    sleep_req = 1'b1; tick(1); sleep_req = 1'b0;
  endtask

  task automatic pulse_wake();
    wake = 1'b1; tick(1); wake = 1'b0;
  endtask

  initial begin
    #2_000_000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int n;
    // R1: reset state
    tick(20);
    chk(run_mode == 3'd0, "R1 run_mode in reset", int'(run_mode), 0);
    chk(pri_active == 1'b0, "R1 pri_active in reset", int'(pri_active), 0);
    chk(sys_edges == 0, "R1 sys_clk quiet in reset", sys_edges, 0);
    por_n = 1'b1;
    tick(30);
    chk(run_mode == 3'd0, "R1 hold until power-up timer", int'(run_mode), 0);
    chk(sys_edges == 0, "R1 sys_clk quiet before power-up timer", sys_edges, 0);

    // R2/R3/R5: crystal without PLL
    push(3'd1, "R2 enter internal run"); push(3'd3, "R5 direct handover");
    pwrt_done = 1'b1;
    wait_mode(3'd1, 20, "R2 internal run after power-up timer");
    tick(10);
    chk(pri_active == 1'b0, "R2 status low on internal clock", int'(pri_active), 0);
    rate(100, n); chk_rng("R2 sys_clk at internal rate", n, 99, 101);
    wait_mode(3'd3, 3000, "R5 reach primary run");
    chk(pri_active == 1'b1, "R11 status with primary run", int'(pri_active), 1);
    chk_rng("R3 start-up wait length", last_dur[1], OST_MIN, OST_MAX);
    tick(10);
    rate(100, n); chk_rng("R5 sys_clk at primary rate", n, 70, 73);

    // R8: sleep, then R4: PLL crystal mode
    pulse_wake();
    tick(5);
    chk(run_mode == 3'd3, "R8 wake ignored outside sleep", int'(run_mode), 3);
    push(3'd4, "R8 sleep entry");
    pulse_sleep();
    wait_mode(3'd4, 3, "R8 in sleep");
    tick(10);
    chk(pri_active == 1'b0, "R8 status low in sleep", int'(pri_active), 0);
    rate(50, n); chk(n == 0, "R8 sys_clk stopped in sleep", n, 0);
    pri_mode = 3'd3;
    push(3'd1, "R2 wake to internal run"); push(3'd2, "R4 lock wait");
    push(3'd3, "R4 primary run via PLL");
    pulse_wake();
    wait_mode(3'd3, 4000, "R4 reach primary run");
    chk_rng("R4 lock length", last_dur[2], LOCK, LOCK);
    tick(10);
    rate(100, n); chk_rng("R4 sys_clk at PLL rate", n, 248, 252);

    // R9: sleep during start-up, immediate wake restarts full wait
    push(3'd4, "R8 sleep entry");
    pulse_sleep();
    tick(3);
    pri_mode = 3'd1;
    push(3'd1, "R9 wake to internal run");
    pulse_wake();
    wait_mode(3'd1, 20, "R9 internal run");
    tick(200);
    push(3'd4, "R9 sleep during start-up");
    pulse_sleep();
    wait_mode(3'd4, 3, "R9 sleep before handover");
    chk(pri_active == 1'b0, "R9 never reached primary", int'(pri_active), 0);
    push(3'd1, "R9 second wake"); push(3'd3, "R9 handover after restart");
    pulse_wake();
    wait_mode(3'd3, 3000, "R9 reach primary run");
    chk_rng("R9 full wait after restart", last_dur[1], OST_MIN, OST_MAX);

    // R10/R11: software keeps the internal clock
    push(3'd4, "R8 sleep entry");
    pulse_sleep();
    tick(5);
    clk_sel = 2'b10;
    push(3'd1, "R10 internal run"); push(3'd3, "R10 handover state");
    pulse_wake();
    wait_mode(3'd3, 3000, "R10 reach primary run state");
    tick(10);
    chk(pri_active == 1'b0, "R10 status low with internal select", int'(pri_active), 0);
    rate(100, n); chk_rng("R10 sys_clk stays internal", n, 99, 101);
    clk_sel = 2'b01;
    tick(10);
    chk(pri_active == 1'b0, "R11 status low for select 01", int'(pri_active), 0);
    clk_sel = 2'b00;
    tick(2);
    chk(pri_active == 1'b1, "R11 status follows select", int'(pri_active), 1);
    tick(10);
    rate(100, n); chk_rng("R10 sys_clk back to primary", n, 70, 73);

    // R7: fast path disabled with a crystal
    push(3'd4, "R8 sleep entry");
    pulse_sleep();
    tick(5);
    cfg_fast_en = 1'b0;
    push(3'd1, "R7 start-up wait"); push(3'd3, "R7 primary run");
    pulse_wake();
    wait_mode(3'd1, 20, "R7 wait state");
    tick(10);
    rate(100, n); chk(n == 0, "R7 sys_clk held during wait", n, 0);
    chk(pri_active == 1'b0, "R7 status low during wait", int'(pri_active), 0);
    wait_mode(3'd3, 3000, "R7 reach primary run");
    chk_rng("R7 wait length", last_dur[1], OST_MIN, OST_MAX);
    tick(10);
    rate(100, n); chk_rng("R7 sys_clk primary after wait", n, 70, 73);
    cfg_fast_en = 1'b1;

    // R6: non-crystal modes skip the wait
    push(3'd4, "R8 sleep entry");
    pulse_sleep();
    tick(5);
    pri_mode = 3'd4;
    push(3'd3, "R6 direct primary run");
    pulse_wake();
    wait_mode(3'd3, 10, "R6 immediate primary run");
    chk(pri_active == 1'b1, "R6 status high at once", int'(pri_active), 1);
    tick(10);
    rate(100, n); chk_rng("R6 sys_clk primary", n, 70, 73);
    push(3'd4, "R8 sleep entry");
    pulse_sleep();
    tick(5);
    pri_mode = 3'd5;
    cfg_fast_en = 1'b0;
    push(3'd3, "R6 direct primary run with fast path off");
    pulse_wake();
    wait_mode(3'd3, 10, "R6 immediate primary run with fast path off");
    tick(10);

    chk(exp_q.size() == 0, "R8 all expected transitions seen", exp_q.size(), 0);
    chk(min_high > 1.9, "R12 no runt pulse on sys_clk", int'(min_high * 1000.0), 2000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule